// File: doc/BRIEF.md
# Card Clock and ETU Generator

This block produces the clock driven onto a smart card contact and the elementary time unit (ETU) strobe that paces the card UART. It runs on a fast system clock `clk` at twice the crystal rate. From that clock a free-running counter makes four divided clocks: the crystal rate, half of it, a quarter of it and an eighth of it. A fifth source toggles on every pulse of `osc_tick`, which marks one period of the slower internal oscillator, so that source runs at half the oscillator rate.

A sequencer picks the card clock. In `SQ_RUN` the card clock follows the active source. A change of ratio waits for a low phase of the old source. The sequencer then moves `SQ_RUN -> SQ_ALIGN` and holds the output low. It returns `SQ_ALIGN -> SQ_RUN` only when the new source is also low, so no high pulse is ever cut short. A stop request moves `SQ_RUN -> SQ_STOP` on a low phase, or `SQ_ALIGN -> SQ_STOP` at once, and parks the output at the chosen level. Releasing the stop goes `SQ_STOP -> SQ_ALIGN`. Synchronous mode enters `SQ_SYNC` from any state and copies a software bit onto the pin. Leaving it goes `SQ_SYNC -> SQ_ALIGN`. Reset starts in `SQ_ALIGN`.

The ETU path counts edges of the active source. It counts rising edges only, or both edges when doubling applies. The edges pass through a prescaler of 31 or 32 and then an 8-bit divider. The result is a strobe one `clk` wide.

Top module: `card_clk_etu`

## Requirements
- R1: With `clk_sel` = 000, 001, 010 or 011, the card clock period in `SQ_RUN` is 2, 4, 8 or 16 `clk` cycles, with a high phase of half the period.
- R2: With `clk_sel[2]` = 1, the card clock toggles once per `osc_tick` pulse, so its period is two oscillator periods.
- R3: A change of `clk_sel` never yields a card-clock high pulse shorter than the shorter high phase of the old and the new source. While the sequencer is in `SQ_ALIGN` the card clock is low.
- R4: With `clk_stop` = 1 and synchronous mode off, the card clock parks low when `stop_level` = 0 and high when `stop_level` = 1.
- R5: With `sync_mode` = 1, `card_clk` equals the `sync_bit` value of the previous cycle.
- R6: `psc_sel` = 0 selects a prescale of 31 source edges per prescaler output and `psc_sel` = 1 selects 32.
- R7: The ETU period is the prescaler period times `etu_div` for `etu_div` in 02h..FFh. Both 00h and 01h give a factor of 1.
- R8: With `dbl_en` = 1, both edges of the source are counted, which halves the ETU period. The exception is `clk_sel` = 000, where `dbl_en` has no effect.
- R9: `etu_stb` is high for exactly one `clk` cycle per ETU.
- R10: A `cfg_load` pulse restarts the prescaler and the divider. The first strobe then follows one full ETU later, within one source period.
- R11: While `pwr_down` = 1 no strobe is issued. The counters hold, and strobes resume after release.
- R12: During reset, `card_clk` and `etu_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at twice the crystal rate |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per internal oscillator period |
| clk_sel | input | 3 | Ratio select (000 /1, 001 /2, 010 /4, 011 /8, 1xx oscillator/2) |
| clk_stop | input | 1 | Park the card clock |
| stop_level | input | 1 | Parking level (0 low, 1 high) |
| sync_mode | input | 1 | Software-driven card clock |
| sync_bit | input | 1 | Card clock value in synchronous mode |
| dbl_en | input | 1 | Count both source edges for the ETU |
| psc_sel | input | 1 | Prescaler select (0 = 31, 1 = 32) |
| etu_div | input | 8 | ETU divider (00h and 01h mean 1) |
| cfg_load | input | 1 | Restart prescaler and divider |
| pwr_down | input | 1 | Freeze the ETU generator |
| card_clk | output | 1 | Card clock pin value |
| etu_stb | output | 1 | One-cycle ETU strobe |

## Verification
A ratio change and a stop request can arrive in the same cycle. Both are then waiting on the same low phase of the old source. The bench provokes this by changing `clk_sel` from 011 to 001 on the very cycle that `clk_stop` rises with a high parking level. It then watches every high pulse for a runt, confirms that the clock parks high, and measures the period of the new ratio after release. A `cfg_load` that falls on a cycle where an edge would count is also covered: the restart takes precedence, and the first-strobe window is judged against that.

// File: rtl/card_clk_etu_pkg.sv
package card_clk_etu_pkg;

    localparam int CLK_SEL_W = 3;
    localparam int N_RATIO   = 4;
    localparam int N_SRC     = N_RATIO + 1;

    typedef enum logic [1:0] {
        SQ_ALIGN = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_STOP  = 2'd2,
        SQ_SYNC  = 2'd3
    } seq_state_t;

    function automatic logic [CLK_SEL_W-1:0] norm_sel(input logic [CLK_SEL_W-1:0] code);
        return code[CLK_SEL_W-1] ? {1'b1, {(CLK_SEL_W-1){1'b0}}} : code;
    endfunction

    function automatic logic src_of(input logic [N_SRC-1:0] vec,
                                    input logic [CLK_SEL_W-1:0] code);
        logic [CLK_SEL_W-2:0] idx;
        idx = code[CLK_SEL_W-2:0];
        return code[CLK_SEL_W-1] ? vec[N_RATIO] : vec[idx];
    endfunction

endpackage

// File: rtl/card_clk_divbank.sv
module card_clk_divbank
    import card_clk_etu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    output logic [N_SRC-1:0] src_vec
);

    logic [N_RATIO-1:0] ratio_cnt;
    logic               osc_half;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_cnt <= '0;
            osc_half  <= 1'b0;
        end else begin
            ratio_cnt <= ratio_cnt + 1'b1;
            if (osc_tick) osc_half <= ~osc_half;
        end
    end

    for (genvar g = 0; g < N_RATIO; g++) begin : g_ratio
        assign src_vec[g] = ratio_cnt[g];
    end
    assign src_vec[N_RATIO] = osc_half;

endmodule

// File: rtl/card_clk_seq.sv
module card_clk_seq
    import card_clk_etu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     src_vec,
    input  logic [CLK_SEL_W-1:0] sel_req,
    input  logic                 clk_stop,
    input  logic                 stop_level,
    input  logic                 sync_mode,
    input  logic                 sync_bit,
    output logic                 card_clk,
    output logic [CLK_SEL_W-1:0] cur_sel,
    output seq_state_t           state
);

    seq_state_t           nxt;
    logic [CLK_SEL_W-1:0] want_sel;
    logic                 cur_lvl;
    logic                 want_lvl;

    assign want_sel = norm_sel(sel_req);
    assign cur_lvl  = src_of(src_vec, cur_sel);
    assign want_lvl = src_of(src_vec, want_sel);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_ALIGN;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            SQ_RUN: begin
                if (sync_mode)                          nxt = SQ_SYNC;
                else if (!cur_lvl && clk_stop)          nxt = SQ_STOP;
                else if (!cur_lvl && want_sel != cur_sel) nxt = SQ_ALIGN;
            end
            SQ_ALIGN: begin
                if (sync_mode)      nxt = SQ_SYNC;
                else if (clk_stop)  nxt = SQ_STOP;
                else if (!want_lvl) nxt = SQ_RUN;
            end
            SQ_STOP: begin
                if (sync_mode)      nxt = SQ_SYNC;
                else if (!clk_stop) nxt = SQ_ALIGN;
            end
            SQ_SYNC: begin
                if (!sync_mode)     nxt = SQ_ALIGN;
            end
            default: nxt = SQ_ALIGN;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_clk <= 1'b0;
            cur_sel  <= '0;
        end else begin
            unique case (state)
                SQ_RUN:   card_clk <= cur_lvl;
                SQ_STOP:  card_clk <= stop_level;
                SQ_SYNC:  card_clk <= sync_bit;
                SQ_ALIGN: card_clk <= 1'b0;
                default:  card_clk <= 1'b0;
            endcase
            if (state == SQ_ALIGN && nxt == SQ_RUN) cur_sel <= want_sel;
        end
    end

endmodule

// File: rtl/card_etu_gen.sv
module card_etu_gen #(
    parameter int PSC_BASE = 31,
    parameter int DIV_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_lvl,
    input  logic             both_edges,
    input  logic             psc_sel,
    input  logic [DIV_W-1:0] etu_div,
    input  logic             cfg_load,
    input  logic             pwr_down,
    output logic             etu_stb
);

    localparam int PSC_W = $clog2(PSC_BASE + 2);

    logic             prev_lvl;
    logic             edge_hit;
    logic             tick;
    logic [PSC_W-1:0] psc_cnt;
    logic [PSC_W-1:0] psc_last;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;
    logic             psc_wrap;
    logic             fire;

    assign edge_hit = both_edges ? (src_lvl ^ prev_lvl) : (src_lvl & ~prev_lvl);
    assign tick     = edge_hit & ~pwr_down & ~cfg_load;
    assign psc_last = psc_sel ? PSC_W'(PSC_BASE) : PSC_W'(PSC_BASE - 1);
    assign div_last = (etu_div < DIV_W'(2)) ? '0 : etu_div - 1'b1;
    assign psc_wrap = tick && (psc_cnt == psc_last);
    assign fire     = psc_wrap && (div_cnt == div_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
            psc_cnt  <= '0;
            div_cnt  <= '0;
            etu_stb  <= 1'b0;
        end else begin
            prev_lvl <= src_lvl;
            etu_stb  <= fire;
            if (cfg_load) begin
                psc_cnt <= '0;
                div_cnt <= '0;
            end else if (tick) begin
                psc_cnt <= psc_wrap ? '0 : psc_cnt + 1'b1;
                if (psc_wrap) div_cnt <= fire ? '0 : div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/card_clk_etu.sv
module card_clk_etu
    import card_clk_etu_pkg::*;
#(
    parameter int PSC_BASE = 31,
    parameter int DIV_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [2:0]       clk_sel,
    input  logic             clk_stop,
    input  logic             stop_level,
    input  logic             sync_mode,
    input  logic             sync_bit,
    input  logic             dbl_en,
    input  logic             psc_sel,
    input  logic [DIV_W-1:0] etu_div,
    input  logic             cfg_load,
    input  logic             pwr_down,
    output logic             card_clk,
    output logic             etu_stb
);

    logic [N_SRC-1:0]     src_vec;
    logic [CLK_SEL_W-1:0] cur_sel;
    seq_state_t           seq_state;
    logic                 src_lvl;
    logic                 both_edges;

    card_clk_divbank u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .src_vec  (src_vec)
    );

    card_clk_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_vec    (src_vec),
        .sel_req    (clk_sel),
        .clk_stop   (clk_stop),
        .stop_level (stop_level),
        .sync_mode  (sync_mode),
        .sync_bit   (sync_bit),
        .card_clk   (card_clk),
        .cur_sel    (cur_sel),
        .state      (seq_state)
    );

    assign src_lvl    = src_of(src_vec, cur_sel);
    assign both_edges = dbl_en && (cur_sel != '0);

    card_etu_gen #(.PSC_BASE(PSC_BASE), .DIV_W(DIV_W)) u_etu (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_lvl    (src_lvl),
        .both_edges (both_edges),
        .psc_sel    (psc_sel),
        .etu_div    (etu_div),
        .cfg_load   (cfg_load),
        .pwr_down   (pwr_down),
        .etu_stb    (etu_stb)
    );

endmodule

// File: rtl/card_clk_etu_chk.sv
module card_clk_etu_chk
    import card_clk_etu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       card_clk,
    input logic       etu_stb,
    input logic       pwr_down,
    input logic       sync_mode,
    input logic       sync_bit,
    input logic       stop_level,
    input seq_state_t seq_state
);

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        etu_stb |=> !etu_stb);

    // R11
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !etu_stb);

    // R5
    sync_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_mode) |=> card_clk == $past(sync_bit));

    // R4
    park_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_STOP && $past(seq_state == SQ_STOP)) |-> card_clk == $past(stop_level));

    // R3
    align_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_state == SQ_ALIGN) |-> !card_clk);

endmodule

bind card_clk_etu card_clk_etu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .card_clk   (card_clk),
    .etu_stb    (etu_stb),
    .pwr_down   (pwr_down),
    .sync_mode  (sync_mode),
    .sync_bit   (sync_bit),
    .stop_level (stop_level),
    .seq_state  (seq_state)
);

// File: tb/card_clk_etu_test.sv
module card_clk_etu_test;

    localparam int OSC_P = 7;
    localparam int LIMIT = 40000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [2:0] clk_sel = 3'b000;
    logic       clk_stop = 1'b0;
    logic       stop_level = 1'b0;
    logic       sync_mode = 1'b0;
    logic       sync_bit = 1'b0;
    logic       dbl_en = 1'b0;
    logic       psc_sel = 1'b0;
    logic [7:0] etu_div = 8'd1;
    logic       cfg_load = 1'b0;
    logic       pwr_down = 1'b0;
    logic       card_clk;
    logic       etu_stb;

    int n_tests = 0;
    int n_fail  = 0;
    bit mon_en  = 1'b0;
    int mon_min = 1;
    int hi_run  = 0;
    bit runt    = 1'b0;
    int runt_w  = 0;

    card_clk_etu uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .clk_sel(clk_sel),
        .clk_stop(clk_stop), .stop_level(stop_level), .sync_mode(sync_mode),
        .sync_bit(sync_bit), .dbl_en(dbl_en), .psc_sel(psc_sel), .etu_div(etu_div),
        .cfg_load(cfg_load), .pwr_down(pwr_down), .card_clk(card_clk), .etu_stb(etu_stb)
    );

    always #10 clk = ~clk;

    // internal oscillator pulse every OSC_P cycles
    int osc_cnt = 0;
    always @(negedge clk) begin
        osc_cnt  <= (osc_cnt == OSC_P - 1) ? 0 : osc_cnt + 1;
        osc_tick <= (osc_cnt == OSC_P - 1);
    end

    // runt monitor for R3
    always @(negedge clk) begin
        if (card_clk) hi_run <= hi_run + 1;
        else begin
            if (mon_en && hi_run != 0 && hi_run < mon_min) begin
                runt   <= 1'b1;
                runt_w <= hi_run;
            end
            hi_run <= 0;
        end
    end

    function automatic int exp_per(input logic [2:0] code);
        return code[2] ? 2 * OSC_P : (2 << code[1:0]);
    endfunction

    function automatic int exp_etu(input logic [2:0] code, input bit ps, input int d, input bit dbl);
        int e;
        e = exp_per(code) * (ps ? 32 : 31) * ((d < 2) ? 1 : d);
        if (dbl && code != 3'b000) e = e / 2;
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic meas_etu(output int iv);
        int n;
        n = 0;
        do begin @(negedge clk); n++; end while (!etu_stb && n < LIMIT);
        n = 0;
        do begin @(negedge clk); n++; end while (!etu_stb && n < LIMIT);
        iv = n;
    endtask

    task automatic meas_card(output int per, output int hi);
        int n;
        n = 0;
        do begin @(negedge clk); n++; end while (card_clk && n < LIMIT);
        do begin @(negedge clk); n++; end while (!card_clk && n < LIMIT);
        hi = 0; per = 0;
        while (card_clk && hi < LIMIT) begin @(negedge clk); hi++; end
        per = hi;
        while (!card_clk && per < LIMIT) begin @(negedge clk); per++; end
    endtask

    task automatic setup(input logic [2:0] code, input bit ps, input int d, input bit dbl);
        clk_sel = code; psc_sel = ps; etu_div = 8'(d); dbl_en = dbl;
        repeat (40) @(negedge clk);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic etu_case(input string req, input logic [2:0] code, input bit ps, input int d, input bit dbl);
        int iv;
        setup(code, ps, d, dbl);
        meas_etu(iv);
        chk(iv == exp_etu(code, ps, d, dbl), req, iv, exp_etu(code, ps, d, dbl));
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int per, hi, iv, t, seen;
        void'($urandom(32'd4242));

        // R12 reset state
        repeat (5) @(negedge clk);
        chk(card_clk == 1'b0, "R12 card_clk in reset", card_clk, 0);
        chk(etu_stb == 1'b0, "R12 etu_stb in reset", etu_stb, 0);
        rst_n = 1'b1;

        // R1 each divided ratio
        for (int c = 0; c < 4; c++) begin
            clk_sel = 3'(c);
            repeat (40) @(negedge clk);
            meas_card(per, hi);
            chk(per == exp_per(3'(c)) && hi == per / 2, "R1 card period", per, exp_per(3'(c)));
        end
        // R2 oscillator source
        clk_sel = 3'b110;
        repeat (40) @(negedge clk);
        meas_card(per, hi);
        chk(per == 2 * OSC_P && hi == OSC_P, "R2 oscillator period", per, 2 * OSC_P);

        // R3 ratio switches with runt monitor
        clk_sel = 3'b011; repeat (40) @(negedge clk);
        runt = 1'b0; mon_min = 1; mon_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            logic [2:0] nc;
            nc = ($urandom % 5 == 4) ? 3'b100 : 3'($urandom % 4);
            mon_min = (exp_per(clk_sel) < exp_per(nc) ? exp_per(clk_sel) : exp_per(nc)) / 2;
            repeat ($urandom % 7) @(negedge clk);
            clk_sel = nc;
            repeat (40) @(negedge clk);
        end
        mon_en = 1'b0;
        chk(!runt, "R3 no runt across switches", runt_w, 0);

        // R4 / R3 stop coinciding with a ratio change
        clk_sel = 3'b011; repeat (40) @(negedge clk);
        runt = 1'b0; mon_min = 2; mon_en = 1'b1;
        while (!card_clk) @(negedge clk);
        clk_sel = 3'b001; clk_stop = 1'b1; stop_level = 1'b1;
        repeat (40) @(negedge clk);
        chk(card_clk == 1'b1, "R4 parked high", card_clk, 1);
        seen = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (!card_clk) seen++; end
        chk(seen == 0, "R4 stays high", seen, 0);
        stop_level = 1'b0;
        repeat (3) @(negedge clk);
        seen = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (card_clk) seen++; end
        chk(seen == 0, "R4 parked low", seen, 0);
        clk_stop = 1'b0;
        meas_card(per, hi);
        mon_en = 1'b0;
        chk(per == 4, "R3 new ratio after stop", per, 4);
        chk(!runt, "R3 no runt with stop", runt_w, 0);

        // R5 synchronous mode
        sync_mode = 1'b1; sync_bit = 1'b0;
        repeat (3) @(negedge clk);
        seen = 0;
        for (int k = 0; k < 16; k++) begin
            bit b;
            b = 1'($urandom);
            sync_bit = b;
            @(negedge clk);
            if (card_clk != b) seen++;
        end
        chk(seen == 0, "R5 sync copy mismatches", seen, 0);
        sync_mode = 1'b0;

        // R6 / R7 directed
        etu_case("R6 prescale 31", 3'b000, 1'b0, 1, 1'b0);
        etu_case("R6 prescale 32", 3'b000, 1'b1, 1, 1'b0);
        etu_case("R7 divider 00h", 3'b000, 1'b0, 0, 1'b0);
        etu_case("R7 divider 02h", 3'b001, 1'b1, 2, 1'b0);
        etu_case("R7 divider FFh", 3'b000, 1'b1, 255, 1'b0);

        // R8 doubler
        etu_case("R8 doubler ignored at 000", 3'b000, 1'b0, 3, 1'b1);
        etu_case("R8 doubler halves", 3'b001, 1'b0, 2, 1'b1);

        // R9 one-cycle strobe
        setup(3'b000, 1'b0, 1, 1'b0);
        seen = 0;
        while (!etu_stb && seen < LIMIT) begin @(negedge clk); seen++; end
        @(negedge clk);
        chk(etu_stb == 1'b0, "R9 strobe width", etu_stb, 0);

        // R10 restart on configuration load
        setup(3'b001, 1'b0, 3, 1'b0);
        repeat (100) @(negedge clk);
        cfg_load = 1'b1; @(negedge clk); cfg_load = 1'b0;
        t = 0;
        while (!etu_stb && t < LIMIT) begin @(negedge clk); t++; end
        chk(t >= 372 - 4 && t <= 372 + 2, "R10 first strobe after load", t, 372);

        // R11 power-down freezes
        setup(3'b000, 1'b0, 2, 1'b0);
        pwr_down = 1'b1;
        seen = 0;
        for (int k = 0; k < 600; k++) begin @(negedge clk); if (etu_stb) seen++; end
        chk(seen == 0, "R11 no strobe in power-down", seen, 0);
        pwr_down = 1'b0;
        t = 0;
        while (!etu_stb && t < LIMIT) begin @(negedge clk); t++; end
        chk(t <= 124 + 2, "R11 resume after release", t, 124);

        // random mix of R1/R2/R6/R7/R8
        for (int k = 0; k < 8; k++) begin
            logic [2:0] c;
            int d;
            bit ps, db;
            c  = ($urandom % 5 == 4) ? 3'b101 : 3'($urandom % 4);
            d  = $urandom % 5;
            ps = 1'($urandom);
            db = 1'($urandom);
            setup(c, ps, d, db);
            meas_card(per, hi);
            chk(per == exp_per(c), "R1 R2 random card period", per, exp_per(c));
            meas_etu(iv);
            chk(iv == exp_etu(c, ps, d, db), "R7 R8 random ETU", iv, exp_etu(c, ps, d, db));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule